// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog built around a wide down-counter. Software reaches it through a simple write-only register port: a set of period words, a key register and a pulse-width register. The watchdog stays idle after reset until software arms it with an ordered pair of key writes, with the enable flag set on the first of the two. Once armed, the counter counts down every clock cycle. Software must keep repeating the same two-key sequence, and each complete sequence reloads the counter. If the counter runs out first, the block drives a timeout pulse whose width is programmable, sets a sticky flag, reloads itself and keeps running.

Software cannot disarm the watchdog. Only the asynchronous reset returns it to the idle state. The reset is applied asynchronously and released synchronously inside the block.

Top module: `keyed_wdt`

## Requirements
- R1: While reset is applied and right after it is released, `armed_o`, `wdt_pulse_o` and `timeout_flag_o` are 0 and `count_o` is 0.
- R2: A key-register write (address 2) carries the key in bits [15:0] and the enable flag in bit 16. The watchdog arms when a write of 16'hA5C6 with bit 16 set is directly followed, on the key register, by a write of 16'hDA7E. `armed_o` is 1 after the second write.
- R3: If any value other than 16'hDA7E is written to the key register after 16'hA5C6, the sequence is dropped. An armed watchdog is not serviced by it. A sequence whose 16'hA5C6 write had bit 16 clear does not arm.
- R4: The timeout count is written low word first to address 0, high word to address 1, and holds the desired count minus one (P). On arming, `count_o` loads P and then falls by one each cycle. The first timeout pulse appears P+1 cycles after the arming write.
- R5: While armed, a complete key sequence sets `count_o` to P in the cycle after its second write, so the timeout never fires as long as service is regular.
- R6: A broken sequence (16'hA5C6, another value, then 16'hDA7E) leaves the counter decrementing without a reload.
- R7: Once armed, no key-register write clears `armed_o`, including one with bit 16 clear. Only reset disarms the watchdog.
- R8: On expiry, `wdt_pulse_o` is high for W+1 cycles, where W is bits [7:0] of address 3. The counter reloads P and runs on, so timeouts repeat every P+1 cycles.
- R9: `timeout_flag_o` sets at the first timeout and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register select: 0/1 period words, 2 key, 3 pulse width |
| wr_data | input | 32 | Write data |
| armed_o | output | 1 | Watchdog armed |
| count_o | output | 64 | Current count value |
| wdt_pulse_o | output | 1 | Timeout pulse |
| timeout_flag_o | output | 1 | Sticky timeout indication |

## Verification
The key tracker shows a corrupted state only through its effect on the counter. If it wrongly accepts a sequence, `count_o` jumps back to P one cycle after the second key. If it wrongly rejects one, the count keeps falling, and the fault shows only when the pulse arrives P+1 cycles later. For that reason the bench compares `count_o` directly after every key write rather than waiting for a timeout. Counter and pulse-width errors show as a first pulse edge, or a pulse length, that is off by whole cycles. The bench counts these exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;
  localparam int unsigned KEY_W      = 16;
  localparam int unsigned ARM_BIT    = 16;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HALF = 1'b1
  } seq_state_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  input  logic             en_bit,
  output logic             arm_evt,
  output logic             svc_evt,
  output logic             armed
);
  seq_state_t st_q, st_d;
  logic       en_pend_q, en_pend_d;
  logic       armed_q, armed_d;
  logic       seq_ok;

  assign seq_ok  = key_wr && (st_q == SEQ_HALF) && (key_val == KEY_SECOND);
  assign arm_evt = seq_ok && !armed_q && en_pend_q;
  assign svc_evt = seq_ok && armed_q;
  assign armed   = armed_q;

  always_comb begin
    st_d      = st_q;
    en_pend_d = en_pend_q;
    if (key_wr) begin
      if (key_val == KEY_FIRST) begin
        st_d      = SEQ_HALF;
        en_pend_d = en_bit;
      end else begin
        st_d      = SEQ_IDLE;
        en_pend_d = 1'b0;
      end
    end
    armed_d = armed_q | arm_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_IDLE;
      en_pend_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      en_pend_q <= en_pend_d;
      armed_q   <= armed_d;
    end
  end

  a_r7_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  a_r2_arm_after_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> ($past(key_wr) && $past(key_val) == KEY_SECOND));
  a_r3_service_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    svc_evt |-> armed_q);
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = armed && !load && at_zero;
  assign count   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = period;
    else if (expire)   cnt_d = period;
    else if (armed)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r4_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load && !at_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r5_load_takes_period: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(period)));
  a_r8_expire_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(period)));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [PW_W-1:0] width,
  output logic            pulse
);
  logic [PW_W-1:0] rem_q, rem_d;
  logic            pulse_q, pulse_d;

  always_comb begin
    rem_d   = rem_q;
    pulse_d = pulse_q;
    if (fire) begin
      pulse_d = 1'b1;
      rem_d   = width;
    end else if (pulse_q) begin
      if (rem_q == '0) pulse_d = 1'b0;
      else             rem_d   = rem_q - PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  a_r8_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse_q);
  a_r8_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && rem_q == '0 && !fire) |=> !pulse_q);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW_W   = 8,
  localparam int unsigned NWORDS = (CNT_W + DATA_W - 1) / DATA_W,
  localparam int unsigned ADDR_W = $clog2(NWORDS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              armed_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              wdt_pulse_o,
  output logic              timeout_flag_o
);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(NWORDS);
  localparam logic [ADDR_W-1:0] PW_ADDR  = ADDR_W'(NWORDS + 1);

  logic                     rst_s_n;
  logic [NWORDS*DATA_W-1:0] period_flat;
  logic [CNT_W-1:0]         period;
  logic [PW_W-1:0]          pw_q, pw_d;
  logic                     flag_q, flag_d;
  logic                     key_wr, arm_evt, svc_evt, armed, expire, pulse;
  logic [CNT_W-1:0]         count;

  wdt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  for (genvar w = 0; w < NWORDS; w++) begin : g_period
    logic [DATA_W-1:0] word_q, word_d;
    logic              word_we;
    assign word_we = wr_en && (wr_addr == ADDR_W'(w));
    always_comb begin
      word_d = word_q;
      if (word_we) word_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) word_q <= '0;
      else          word_q <= word_d;
    end
    assign period_flat[w*DATA_W +: DATA_W] = word_q;
  end

  assign period = period_flat[CNT_W-1:0];

  always_comb begin
    pw_d = pw_q;
    if (wr_en && wr_addr == PW_ADDR) pw_d = wr_data[PW_W-1:0];
    flag_d = flag_q | expire;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pw_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      pw_q   <= pw_d;
      flag_q <= flag_d;
    end
  end

  assign key_wr = wr_en && (wr_addr == KEY_ADDR);

  wdt_key_seq u_keys (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .key_wr  (key_wr),
    .key_val (wr_data[KEY_W-1:0]),
    .en_bit  (wr_data[ARM_BIT]),
    .arm_evt (arm_evt),
    .svc_evt (svc_evt),
    .armed   (armed)
  );

  wdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .armed  (armed),
    .load   (arm_evt | svc_evt),
    .period (period),
    .count  (count),
    .expire (expire)
  );

  wdt_pulse_gen #(.PW_W(PW_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_s_n),
    .fire  (expire),
    .width (pw_q),
    .pulse (pulse)
  );

  assign armed_o        = armed;
  assign count_o        = count;
  assign wdt_pulse_o    = pulse;
  assign timeout_flag_o = flag_q;

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    flag_q |=> flag_q);
  a_r9_pulse_implies_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    pulse |-> flag_q);
  a_r1_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    !armed |-> (!pulse && !flag_q));
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        armed_o;
  logic [63:0] count_o;
  logic        wdt_pulse_o;
  logic        timeout_flag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [31:0] K1    = 32'h0000_A5C6;
  localparam logic [31:0] K1_EN = 32'h0001_A5C6;
  localparam logic [31:0] K2    = 32'h0000_DA7E;

  // {expected armed after the write, key-register write data}
  localparam logic [32:0] VEC [0:8] = '{
    {1'b0, K1},             // R3: no enable flag
    {1'b0, K2},             // R3: completes, still not armed
    {1'b0, K1_EN},
    {1'b0, 32'h0000_1234},  // R3: broken
    {1'b0, K2},             // R3: orphan second key
    {1'b0, K1_EN},
    {1'b1, K2},             // R2: arms
    {1'b1, K1},             // R7: enable clear, still armed
    {1'b1, K2}              // R7: still armed
  };

  keyed_wdt dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .armed_o(armed_o), .count_o(count_o), .wdt_pulse_o(wdt_pulse_o),
    .timeout_flag_o(timeout_flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic set_period(input logic [63:0] p);
    wr(2'd0, p[31:0]);
    wr(2'd1, p[63:32]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first_rise;
    int high_cnt;
    int second_rise;
    logic [63:0] c0;

    // R1: reset state
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(posedge clk); #1;
    chk("R1 armed in reset", armed_o, 0);
    chk("R1 pulse in reset", wdt_pulse_o, 0);
    do_reset();
    chk("R1 flag after reset", timeout_flag_o, 0);
    chk("R1 count after reset", count_o, 0);

    // R2/R3/R7 vector walk
    set_period(64'd1000);
    for (int i = 0; i < 9; i++) begin
      wr(2'd2, VEC[i][31:0]);
      chk($sformatf("R2/R3/R7 vector %0d armed", i), armed_o, VEC[i][32]);
    end

    // R4: 64-bit period loads on arming
    do_reset();
    set_period({32'h1, 32'h5});
    wr(2'd2, K1_EN);
    wr(2'd2, K2);
    chk("R4 count loads 64-bit period", count_o, {32'h1, 32'h5});
    @(posedge clk); #1;
    chk("R4 count decrements", count_o, {32'h1, 32'h4});

    // R4/R8/R9: expiry timing, width, repeat, sticky flag
    do_reset();
    set_period(64'd9);
    wr(2'd3, 32'd2);
    wr(2'd2, K1_EN);
    wr(2'd2, K2);
    first_rise = 0; high_cnt = 0; second_rise = 0;
    for (int k = 1; k <= 24; k++) begin
      @(posedge clk); #1;
      if (k == 9) chk("R9 flag clear before expiry", timeout_flag_o, 0);
      if (wdt_pulse_o) begin
        if (first_rise == 0) first_rise = k;
        if (k < 18) high_cnt++;
        if (k >= 18 && second_rise == 0) second_rise = k;
      end
      if (k == 15) chk("R9 flag sticky after pulse", timeout_flag_o, 1);
    end
    chk("R4 first pulse at P+1", 64'(first_rise), 10);
    chk("R8 pulse width W+1", 64'(high_cnt), 3);
    chk("R8 repeat after P+1", 64'(second_rise), 20);
    chk("R7 still armed after timeouts", armed_o, 1);

    // R5: regular service prevents timeout
    do_reset();
    set_period(64'd19);
    wr(2'd2, K1_EN);
    wr(2'd2, K2);
    high_cnt = 0;
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < 8; k++) begin
        @(posedge clk); #1;
        if (wdt_pulse_o) high_cnt++;
      end
      wr(2'd2, K1);
      wr(2'd2, K2);
      chk($sformatf("R5 service %0d reloads", s), count_o, 19);
    end
    chk("R5 no pulse while serviced", 64'(high_cnt), 0);
    chk("R5 no flag while serviced", timeout_flag_o, 0);

    // R6: broken service does not reload
    c0 = count_o;
    wr(2'd2, K1);
    wr(2'd2, 32'h0000_1111);
    wr(2'd2, K2);
    chk("R6 broken sequence no reload", count_o, c0 - 3);
    wr(2'd2, K1);
    wr(2'd2, K2);
    chk("R5 service after broken one", count_o, 19);

    // R7: only reset disarms
    wr(2'd2, 32'h0000_0000);
    chk("R7 junk write keeps armed", armed_o, 1);
    do_reset();
    chk("R7 reset disarms", armed_o, 0);
    chk("R9 reset clears flag", timeout_flag_o, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule